// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block turns one memory-access request into a data-space address. A request carries an access mode, a pointer choice, a 6-bit unsigned offset, a 16-bit absolute address and a snapshot of the three 16-bit pointers. Each pointer is a pair of 8-bit working registers: pointer A is registers 26 (low) and 27 (high), pointer B is 28/29 and pointer C is 30/31. The block produces the effective address and its region in the data map. It also produces the program-memory word and byte select for constant fetches, and the new pointer value that must be written back for the auto-update modes.

A small sequencer handles each request in three states. In `ST_IDLE` the block shows `ready` and takes a request on `req`. `ST_IDLE -> ST_ADDR` happens on an accepted request. In `ST_ADDR` the address outputs are valid for exactly one cycle. If the request updates a pointer, `ST_ADDR -> ST_WBACK`; otherwise `ST_ADDR -> ST_IDLE`. In `ST_WBACK` the write-back is valid for one cycle, and then `ST_WBACK -> ST_IDLE` always follows. The request is captured when it is accepted, so the inputs may change afterwards.

Top module: `ptr_addr_gen`

## Requirements
- R1: Out of reset, `ready` is 1 and `addr_valid` and `wb_valid` are 0. At any time exactly one of `ready`, `addr_valid` or `wb_valid` is 1.
- R2: A request sampled while `ready` is 1 makes `addr_valid` high for exactly the next cycle, with `ready` low in that cycle. A `req` raised while `ready` is 0 is ignored and produces no address.
- R3: Mode code 1 (indirect) gives `eff_addr` equal to the chosen pointer and no write-back. `ptr_sel` codes are 0 = A, 1 = B and 2 = C.
- R4: Mode code 3 (pre-decrement) gives `eff_addr` = pointer − 1 (mod 2^16). In the next cycle `wb_valid` carries that same value, with `wb_reg` = 26, 28 or 30 naming the low register of the pointer.
- R5: Mode code 4 (post-increment) gives `eff_addr` = the old pointer. In the next cycle `wb_valid` carries pointer + 1 (mod 2^16), with `wb_reg` as in R4.
- R6: Mode code 2 (displacement) gives `eff_addr` = pointer + zero-extended `disp` (0..63) for pointers B and C. The pointer is not written back.
- R7: Mode code 0 (direct) gives `eff_addr` = `direct_addr`, whatever `ptr_sel` holds.
- R8: For data modes, `region` is 0 for 0x00–0x1F (register file), 1 for 0x20–0x5F (I/O) and 2 for 0x60 up to `SRAM_LAST` (default 0x25F). Above `SRAM_LAST`, `region` is 3 and `out_of_range` is 1.
- R9: Mode code 6 (short I/O) gives `eff_addr` = 0x20 + `disp`, so I/O numbers 0x00–0x3F land in region 1.
- R10: Mode code 5 (constant fetch) always uses pointer C. It gives `code_fetch` = 1, `code_word` = C[15:1], `code_hi_byte` = C[0], `eff_addr` = C, `region` = 3, `out_of_range` = 0 and no write-back.
- R11: Mode code 7, `ptr_sel` = 3 in a pointer mode (codes 1–4), or displacement on pointer A gives `bad_req` = 1, `eff_addr` = 0, `region` = 3 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when `ready` is 1 |
| mode | input | 3 | Access mode code |
| ptr_sel | input | 2 | Pointer choice: 0 A, 1 B, 2 C |
| disp | input | 6 | Unsigned offset or short I/O number |
| direct_addr | input | 16 | Absolute address for direct mode |
| pa_lo | input | 8 | Pointer A low byte (register 26) |
| pa_hi | input | 8 | Pointer A high byte (register 27) |
| pb_lo | input | 8 | Pointer B low byte (register 28) |
| pb_hi | input | 8 | Pointer B high byte (register 29) |
| pc_lo | input | 8 | Pointer C low byte (register 30) |
| pc_hi | input | 8 | Pointer C high byte (register 31) |
| ready | output | 1 | Sequencer idle, request accepted |
| addr_valid | output | 1 | Address outputs valid this cycle |
| eff_addr | output | 16 | Effective data address |
| region | output | 2 | 0 register file, 1 I/O, 2 SRAM, 3 none |
| out_of_range | output | 1 | Address above the SRAM top |
| bad_req | output | 1 | Illegal mode/pointer combination |
| code_fetch | output | 1 | Program-memory constant fetch |
| code_word | output | 15 | Program word address |
| code_hi_byte | output | 1 | 1 selects the high byte of the word |
| wb_valid | output | 1 | Pointer write-back valid this cycle |
| wb_reg | output | 5 | Low register number of the written pointer |
| wb_lo | output | 8 | New pointer low byte |
| wb_hi | output | 8 | New pointer high byte |

## Verification
The hardest situations to reach are the wrap edges of the auto-update modes. One is pre-decrement of pointer C at 0x0000, which must give 0xFFFF both as an out-of-range address and as the write-back. The other is post-increment of 0xFFFF, which must address 0xFFFF and write back 0x0000. Both come from loading the pointer snapshot inputs with those values. A second hard case is a request raised while the sequencer sits in `ST_ADDR` and held through `ST_WBACK`. The stimulus does this right after a pre-decrement. The scoreboard then shows that no extra address appears.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4,
        AM_CODE    = 3'd5,
        AM_IOSHORT = 3'd6,
        AM_RSVD    = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        RG_REGF = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_NONE = 2'd3
    } rg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WBACK = 2'd2
    } st_e;

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux
    import agu_pkg::*;
#(
    parameter int PTR_COUNT = 3,
    parameter int FIRST_REG = 26,
    parameter int CODE_PTR  = 2
) (
    input  logic [PTR_COUNT*DW-1:0] lo_bus,
    input  logic [PTR_COUNT*DW-1:0] hi_bus,
    input  logic [1:0]              sel,
    input  logic                    code_mode,
    output logic [AW-1:0]           ptr,
    output logic [4:0]              reg_idx,
    output logic                    sel_ok
);
    localparam logic [1:0] CODE_SEL  = 2'(CODE_PTR);
    localparam logic [4:0] FIRST_IDX = 5'(FIRST_REG);

    logic [AW-1:0] ptr_arr [PTR_COUNT];
    logic [1:0]    eff_sel;

    for (genvar g = 0; g < PTR_COUNT; g++) begin : g_pair
        assign ptr_arr[g] = {hi_bus[g*DW +: DW], lo_bus[g*DW +: DW]};
    end

    always_comb begin
        eff_sel = code_mode ? CODE_SEL : sel;
        sel_ok  = (int'(eff_sel) < PTR_COUNT);
        ptr     = sel_ok ? ptr_arr[eff_sel] : '0;
        reg_idx = FIRST_IDX + {2'b00, eff_sel, 1'b0};
    end
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
    import agu_pkg::*;
#(
    parameter int DISP_W  = 6,
    parameter int IO_BASE = 32
) (
    input  am_e              mode,
    input  logic [1:0]       sel,
    input  logic             sel_ok,
    input  logic [AW-1:0]    ptr,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]    direct,
    output logic [AW-1:0]    ea,
    output logic [AW-1:0]    new_ptr,
    output logic             upd,
    output logic             bad,
    output logic             is_code
);
    localparam logic [AW-1:0] IO_OFS = AW'(IO_BASE);
    localparam logic [AW-1:0] ONE    = AW'(1);

    logic [AW-1:0] disp_ext;
    assign disp_ext = {{(AW-DISP_W){1'b0}}, disp};

    always_comb begin
        ea      = '0;
        new_ptr = ptr;
        upd     = 1'b0;
        bad     = 1'b0;
        is_code = 1'b0;
        unique case (mode)
            AM_DIRECT:  ea = direct;
            AM_IND: begin
                ea  = ptr;
                bad = !sel_ok;
            end
            AM_DISP: begin
                ea  = ptr + disp_ext;
                bad = !sel_ok || (sel == 2'd0);
            end
            AM_PREDEC: begin
                new_ptr = ptr - ONE;
                ea      = new_ptr;
                upd     = 1'b1;
                bad     = !sel_ok;
            end
            AM_POSTINC: begin
                new_ptr = ptr + ONE;
                ea      = ptr;
                upd     = 1'b1;
                bad     = !sel_ok;
            end
            AM_CODE: begin
                ea      = ptr;
                is_code = 1'b1;
            end
            AM_IOSHORT: ea  = IO_OFS + disp_ext;
            AM_RSVD:    bad = 1'b1;
        endcase
        if (bad) begin
            ea  = '0;
            upd = 1'b0;
        end
    end
endmodule

// File: rtl/agu_region.sv
module agu_region
    import agu_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int IO_COUNT  = 64,
    parameter int SRAM_LAST = 'h25F
) (
    input  logic [AW-1:0] ea,
    input  logic          data_acc,
    output rg_e           region,
    output logic          oor
);
    localparam logic [AW-1:0] IO_BASE_A   = AW'(REG_COUNT);
    localparam logic [AW-1:0] SRAM_BASE_A = AW'(REG_COUNT + IO_COUNT);
    localparam logic [AW-1:0] SRAM_LAST_A = AW'(SRAM_LAST);

    always_comb begin
        region = RG_NONE;
        oor    = 1'b0;
        if (data_acc) begin
            if (ea < IO_BASE_A)         region = RG_REGF;
            else if (ea < SRAM_BASE_A)  region = RG_IO;
            else if (ea <= SRAM_LAST_A) region = RG_SRAM;
            else                        oor    = 1'b1;
        end
    end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import agu_pkg::*;
#(
    parameter int DISP_W    = 6,
    parameter int REG_COUNT = 32,
    parameter int IO_COUNT  = 64,
    parameter int SRAM_LAST = 'h25F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [2:0]    mode,
    input  logic [1:0]    ptr_sel,
    input  logic [5:0]    disp,
    input  logic [15:0]   direct_addr,
    input  logic [7:0]    pa_lo,
    input  logic [7:0]    pa_hi,
    input  logic [7:0]    pb_lo,
    input  logic [7:0]    pb_hi,
    input  logic [7:0]    pc_lo,
    input  logic [7:0]    pc_hi,
    output logic          ready,
    output logic          addr_valid,
    output logic [15:0]   eff_addr,
    output logic [1:0]    region,
    output logic          out_of_range,
    output logic          bad_req,
    output logic          code_fetch,
    output logic [14:0]   code_word,
    output logic          code_hi_byte,
    output logic          wb_valid,
    output logic [4:0]    wb_reg,
    output logic [7:0]    wb_lo,
    output logic [7:0]    wb_hi
);
    localparam int PTR_COUNT = 3;

    st_e                    state;
    am_e                    cap_mode;
    logic [1:0]             cap_sel;
    logic [DISP_W-1:0]      cap_disp;
    logic [AW-1:0]          cap_direct;
    logic [PTR_COUNT*DW-1:0] cap_lo;
    logic [PTR_COUNT*DW-1:0] cap_hi;

    logic [AW-1:0] sel_ptr;
    logic [4:0]    sel_reg;
    logic          sel_ok;
    logic [AW-1:0] calc_ea;
    logic [AW-1:0] calc_new;
    logic          calc_upd;
    logic          calc_bad;
    logic          calc_code;
    rg_e           calc_rg;
    logic          calc_oor;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode   <= AM_DIRECT;
            cap_sel    <= '0;
            cap_disp   <= '0;
            cap_direct <= '0;
            cap_lo     <= '0;
            cap_hi     <= '0;
        end else if (state == ST_IDLE && req) begin
            cap_mode   <= am_e'(mode);
            cap_sel    <= ptr_sel;
            cap_disp   <= disp;
            cap_direct <= direct_addr;
            cap_lo     <= {pc_lo, pb_lo, pa_lo};
            cap_hi     <= {pc_hi, pb_hi, pa_hi};
        end
    end

    agu_ptr_mux #(
        .PTR_COUNT (PTR_COUNT),
        .FIRST_REG (26),
        .CODE_PTR  (2)
    ) u_mux (
        .lo_bus    (cap_lo),
        .hi_bus    (cap_hi),
        .sel       (cap_sel),
        .code_mode (cap_mode == AM_CODE),
        .ptr       (sel_ptr),
        .reg_idx   (sel_reg),
        .sel_ok    (sel_ok)
    );

    agu_ea_calc #(
        .DISP_W  (DISP_W),
        .IO_BASE (REG_COUNT)
    ) u_calc (
        .mode    (cap_mode),
        .sel     (cap_sel),
        .sel_ok  (sel_ok),
        .ptr     (sel_ptr),
        .disp    (cap_disp),
        .direct  (cap_direct),
        .ea      (calc_ea),
        .new_ptr (calc_new),
        .upd     (calc_upd),
        .bad     (calc_bad),
        .is_code (calc_code)
    );

    agu_region #(
        .REG_COUNT (REG_COUNT),
        .IO_COUNT  (IO_COUNT),
        .SRAM_LAST (SRAM_LAST)
    ) u_region (
        .ea       (calc_ea),
        .data_acc (!calc_bad && !calc_code),
        .region   (calc_rg),
        .oor      (calc_oor)
    );

    // state register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (req) state <= ST_ADDR;
                ST_ADDR:  state <= calc_upd ? ST_WBACK : ST_IDLE;
                ST_WBACK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready        = 1'b0;
        addr_valid   = 1'b0;
        eff_addr     = '0;
        region       = RG_NONE;
        out_of_range = 1'b0;
        bad_req      = 1'b0;
        code_fetch   = 1'b0;
        code_word    = '0;
        code_hi_byte = 1'b0;
        wb_valid     = 1'b0;
        wb_reg       = '0;
        wb_lo        = '0;
        wb_hi        = '0;
        unique case (state)
            ST_IDLE: ready = 1'b1;
            ST_ADDR: begin
                addr_valid   = 1'b1;
                eff_addr     = calc_ea;
                region       = calc_rg;
                out_of_range = calc_oor;
                bad_req      = calc_bad;
                code_fetch   = calc_code;
                if (calc_code) begin
                    code_word    = calc_ea[AW-1:1];
                    code_hi_byte = calc_ea[0];
                end
            end
            ST_WBACK: begin
                wb_valid = 1'b1;
                wb_reg   = sel_reg;
                wb_lo    = calc_new[DW-1:0];
                wb_hi    = calc_new[AW-1:DW];
            end
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [2:0]  mode,
    input logic        ready,
    input logic        addr_valid,
    input logic [15:0] eff_addr,
    input logic [1:0]  region,
    input logic        out_of_range,
    input logic        bad_req,
    input logic        code_fetch,
    input logic        wb_valid,
    input logic [7:0]  wb_lo,
    input logic [7:0]  wb_hi
);
    // R1
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ready, addr_valid, wb_valid}) == 1);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> addr_valid);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

    // R4
    predec_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(mode, 2) == 3'd3) |-> ({wb_hi, wb_lo} == $past(eff_addr)));

    // R5
    postinc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(mode, 2) == 3'd4) |-> ({wb_hi, wb_lo} == $past(eff_addr) + 16'd1));

    // R8
    oor_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (addr_valid && region == 2'd3));

    // R10
    code_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_fetch |=> !wb_valid);

    // R11
    bad_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> !wb_valid);
endmodule

bind ptr_addr_gen agu_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .mode         (mode),
    .ready        (ready),
    .addr_valid   (addr_valid),
    .eff_addr     (eff_addr),
    .region       (region),
    .out_of_range (out_of_range),
    .bad_req      (bad_req),
    .code_fetch   (code_fetch),
    .wb_valid     (wb_valid),
    .wb_lo        (wb_lo),
    .wb_hi        (wb_hi)
);

// File: tb/sim_ptr_addr_gen.sv
`timescale 1ns/1ps
module sim_ptr_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp = '0;
    logic [15:0] direct_addr = '0;
    logic [7:0]  pa_lo = '0, pa_hi = '0, pb_lo = '0, pb_hi = '0, pc_lo = '0, pc_hi = '0;
    logic        ready, addr_valid, out_of_range, bad_req, code_fetch, code_hi_byte, wb_valid;
    logic [15:0] eff_addr;
    logic [1:0]  region;
    logic [14:0] code_word;
    logic [4:0]  wb_reg;
    logic [7:0]  wb_lo, wb_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ptr_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ptr_sel(ptr_sel),
        .disp(disp), .direct_addr(direct_addr),
        .pa_lo(pa_lo), .pa_hi(pa_hi), .pb_lo(pb_lo), .pb_hi(pb_hi),
        .pc_lo(pc_lo), .pc_hi(pc_hi),
        .ready(ready), .addr_valid(addr_valid), .eff_addr(eff_addr),
        .region(region), .out_of_range(out_of_range), .bad_req(bad_req),
        .code_fetch(code_fetch), .code_word(code_word), .code_hi_byte(code_hi_byte),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    typedef struct {
        string       tag;
        logic [15:0] ea;
        logic [1:0]  rg;
        logic        oor;
        logic        bad;
        logic        code;
        logic [14:0] cw;
        logic        chi;
        logic        has_wb;
        logic [4:0]  wreg;
        logic [15:0] wval;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    bit   pend_wb = 0;

    task automatic note(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                                   input logic [15:0] da, input logic [15:0] a,
                                   input logic [15:0] b, input logic [15:0] c, input string tag);
        exp_t e;
        logic [15:0] p;
        bit ptr_mode;
        e.tag = tag; e.ea = 0; e.rg = 3; e.oor = 0; e.bad = 0; e.code = 0;
        e.cw = 0; e.chi = 0; e.has_wb = 0; e.wreg = 0; e.wval = 0;
        ptr_mode = (m >= 3'd1 && m <= 3'd4);
        p = (s == 0) ? a : (s == 1) ? b : c;
        if (m == 3'd7 || (ptr_mode && s == 3) || (m == 3'd2 && s == 0)) begin
            e.bad = 1;
            return e;
        end
        case (m)
            3'd0: e.ea = da;
            3'd1: e.ea = p;
            3'd2: e.ea = p + {10'd0, d};
            3'd3: begin e.ea = p - 16'd1; e.has_wb = 1; e.wval = p - 16'd1; end
            3'd4: begin e.ea = p; e.has_wb = 1; e.wval = p + 16'd1; end
            3'd5: begin e.ea = c; e.code = 1; e.cw = c[15:1]; e.chi = c[0]; return e; end
            default: e.ea = 16'h0020 + {10'd0, d};
        endcase
        e.wreg = 5'd26 + 5'(2 * s);
        if (e.ea < 16'h20)       e.rg = 0;
        else if (e.ea < 16'h60)  e.rg = 1;
        else if (e.ea <= 16'h25F) e.rg = 2;
        else begin e.rg = 3; e.oor = 1; end
        return e;
    endfunction

    task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                         input logic [15:0] da, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input string tag);
        while (!ready) @(negedge clk);
        mode = m; ptr_sel = s; disp = d; direct_addr = da;
        {pa_hi, pa_lo} = a; {pb_hi, pb_lo} = b; {pc_hi, pc_lo} = c;
        req = 1'b1;
        sb.push_back(model(m, s, d, da, a, b, c, tag));
        @(negedge clk);
        req = 1'b0;
        mode = 3'd0; direct_addr = 16'hDEAD; {pc_hi, pc_lo} = 16'hBEEF;
        // R2: address appears one cycle after acceptance, sequencer busy
        note(addr_valid && !ready, "R2 accept timing", {ready, addr_valid}, 2'b01);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_wb || wb_valid)
                note(wb_valid == pend_wb, {cur.tag, " wb presence"}, wb_valid, pend_wb);
            if (pend_wb && wb_valid)
                note({wb_reg, wb_hi, wb_lo} == {cur.wreg, cur.wval}, {cur.tag, " wb value"},
                     {wb_reg, wb_hi, wb_lo}, {cur.wreg, cur.wval});
            pend_wb = 0;
            if (addr_valid) begin
                if (sb.size() == 0) begin
                    note(0, "R2 unexpected address", eff_addr, 0);
                end else begin
                    cur = sb.pop_front();
                    note({eff_addr, region, out_of_range, bad_req, code_fetch, code_word, code_hi_byte} ==
                         {cur.ea, cur.rg, cur.oor, cur.bad, cur.code, cur.cw, cur.chi},
                         {cur.tag, " address"},
                         {eff_addr, region, out_of_range, bad_req, code_fetch, code_word, code_hi_byte},
                         {cur.ea, cur.rg, cur.oor, cur.bad, cur.code, cur.cw, cur.chi});
                    pend_wb = cur.has_wb;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        note(ready && !addr_valid && !wb_valid, "R1 reset state", {ready, addr_valid, wb_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        note(ready && !addr_valid && !wb_valid, "R1 idle after reset", {ready, addr_valid, wb_valid}, 3'b100);

        issue(3'd1, 2'd0, 6'd0, 16'h0, 16'h0010, 16'h0, 16'h0, "R3 indirect A regfile");
        issue(3'd1, 2'd1, 6'd0, 16'h0, 16'h0, 16'h0045, 16'h0, "R3 indirect B io");
        issue(3'd1, 2'd2, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0123, "R3 indirect C sram");
        issue(3'd0, 2'd3, 6'd0, 16'h0100, 16'h0, 16'h0, 16'h0, "R7 direct sram");
        issue(3'd0, 2'd0, 6'd0, 16'h025F, 16'h0, 16'h0, 16'h0, "R8 top of sram");
        issue(3'd0, 2'd0, 6'd0, 16'h0260, 16'h0, 16'h0, 16'h0, "R8 just out of range");
        issue(3'd0, 2'd0, 6'd0, 16'h001F, 16'h0, 16'h0, 16'h0, "R8 last regfile");
        issue(3'd0, 2'd0, 6'd0, 16'h005F, 16'h0, 16'h0, 16'h0, "R8 last io");
        issue(3'd2, 2'd1, 6'd63, 16'h0, 16'h0, 16'h0050, 16'h0, "R6 disp B max");
        issue(3'd2, 2'd2, 6'd1, 16'h0, 16'h0, 16'h0, 16'h001F, "R6 disp C into io");
        issue(3'd2, 2'd0, 6'd5, 16'h0, 16'h0040, 16'h0, 16'h0, "R11 disp on A");
        issue(3'd3, 2'd0, 6'd0, 16'h0, 16'h0061, 16'h0, 16'h0, "R4 predec A");
        issue(3'd3, 2'd2, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0000, "R4 predec C wrap");
        issue(3'd4, 2'd1, 6'd0, 16'h0, 16'h0, 16'h005F, 16'h0, "R5 postinc B");
        issue(3'd4, 2'd2, 6'd0, 16'h0, 16'h0, 16'h0, 16'hFFFF, "R5 postinc C wrap");
        issue(3'd6, 2'd0, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R9 short io first");
        issue(3'd6, 2'd0, 6'd63, 16'h0, 16'h0, 16'h0, 16'h0, "R9 short io last");
        issue(3'd5, 2'd0, 6'd0, 16'h0, 16'h1111, 16'h2222, 16'h1235, "R10 code hi byte");
        issue(3'd5, 2'd1, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0FFE, "R10 code lo byte");
        issue(3'd1, 2'd3, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R11 bad pointer");
        issue(3'd7, 2'd0, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R11 reserved mode");
        issue(3'd4, 2'd3, 6'd0, 16'h0, 16'h0, 16'h0, 16'h0, "R11 bad postinc");

        // R2: request raised while busy must be ignored
        issue(3'd3, 2'd1, 6'd0, 16'h0, 16'h0, 16'h0070, 16'h0, "R4 predec before busy req");
        mode = 3'd0; direct_addr = 16'h1234; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        note(!addr_valid, "R2 busy request ignored", addr_valid, 1'b0);

        repeat (4) @(negedge clk);
        note(sb.size() == 0, "R2 all requests answered", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule